// File: doc/BRIEF.md
# Environment Configuration Register Pair

This block keeps two 64-bit environment configuration words for a RISC-V style hart: a machine-level word and a hypervisor-level word. Software reaches both through one CSR access port that decodes the address. In 64-bit mode each word is read and written whole. In 32-bit mode each word is split into a low-half and a high-half CSR address. The high half is returned in the low 32 bits of the read data.

Three static strap inputs say whether the hart implements three extensions: page-based memory types, supervisor timer compare, and hardware accessed/dirty bit update. Each strap decides whether the matching enable bit of the machine word can be written. The hypervisor word depends on the machine word. A hypervisor enable bit can only be written while the machine bit is set, and it reads as zero while the machine bit is clear. The block gives the resulting host and guest enables to the address-translation logic and to the timer logic.

Top module: `envcfg_pair`

## Requirements
- R1: In 64-bit mode a machine write changes bits 0, 4, 5, 6 and 7, plus bit 61 (A/D update), bit 62 (memory types) and bit 63 (timer compare) when the matching strap is 1. A read returns the stored word.
- R2: A machine enable bit at 61, 62 or 63 whose strap is 0 keeps its value through every write.
- R3: Every bit other than 0, 4–7 and 61–63 of both words reads as zero in all cases.
- R4: A synchronous reset sets bit 62 of both words when the memory-type strap is 1 and bit 61 of both words when the A/D strap is 1. Every other bit is cleared.
- R5: A hypervisor write changes bits 0 and 4–7. It changes bit 61, 62 or 63 only when that bit is 1 in the machine word at the time of the write.
- R6: A hypervisor read returns 0 at bit 61, 62 or 63 whenever the machine bit is 0, even if the stored hypervisor bit is 1. The stored bit is seen again once the machine bit is set.
- R7: In 32-bit mode the low address reaches bits 31:0 and the high address reaches bits 63:32, both through data bits 31:0. Read data bits 63:32 are zero. The hypervisor high read applies the R6 masking.
- R8: In 64-bit mode the two high-half addresses, and in every mode any unknown address, raise the miss flag. Such an access returns zero and writes nothing.
- R9: Read data is valid in the same cycle as the access. A write takes effect at the next rising clock edge.
- R10: The host memory-type and A/D enables equal machine bits 62 and 61. Each guest enable is the AND of the machine bit and the stored hypervisor bit. The timer enables follow the same rule at bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rv64_i | input | 1 | 1 = 64-bit register view, 0 = 32-bit split view |
| has_pmt_i | input | 1 | Memory-type extension present |
| has_tmr_i | input | 1 | Timer-compare extension present |
| has_adu_i | input | 1 | A/D hardware update extension present |
| csr_sel_i | input | 1 | CSR access valid this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data, same cycle |
| csr_miss_o | output | 1 | Address not present in the current mode |
| host_pmt_en_o | output | 1 | Memory types enabled for host translation |
| host_adu_en_o | output | 1 | A/D update enabled for host translation |
| guest_pmt_en_o | output | 1 | Memory types enabled for guest first stage |
| guest_adu_en_o | output | 1 | A/D update enabled for guest first stage |
| s_tmr_en_o | output | 1 | Supervisor timer compare enabled |
| vs_tmr_en_o | output | 1 | Guest supervisor timer compare enabled |

## Verification
The assertions assume that the three straps and the mode input change only while reset is held. They also assume that write data is looked at only when select and write enable are both high. The stimulus follows this: the bench changes straps and mode only inside its reset task, and between accesses it drops select. The stimulus covers several strap mixes in both modes, and then a pseudo-random sweep over all four addresses and two unknown ones.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;

    localparam int unsigned CFG_W   = 64;
    localparam int unsigned HALF_W  = CFG_W / 2;
    localparam int unsigned ADU_POS = 61;
    localparam int unsigned PMT_POS = 62;
    localparam int unsigned TMR_POS = 63;

    // Low-half fields: fence mode bit 0, cache-block controls 7:4
    localparam logic [CFG_W-1:0] BASE_MASK = 64'h0000_0000_0000_00F1;
    localparam logic [CFG_W-1:0] EXT_FIELDS =
        (64'd1 << ADU_POS) | (64'd1 << PMT_POS) | (64'd1 << TMR_POS);

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_M_LO,
        TGT_M_HI,
        TGT_H_LO,
        TGT_H_HI
    } csr_tgt_e;

    typedef struct packed {
        logic pmt;
        logic tmr;
        logic adu;
    } ext_set_t;

    typedef struct packed {
        logic             m_wr;
        logic             h_wr;
        logic [CFG_W-1:0] lane;
        logic [CFG_W-1:0] data;
    } wr_req_t;

    function automatic logic [CFG_W-1:0] ext_bits(ext_set_t e);
        logic [CFG_W-1:0] r;
        r = '0;
        r[ADU_POS] = e.adu;
        r[PMT_POS] = e.pmt;
        r[TMR_POS] = e.tmr;
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] reset_word(ext_set_t e);
        logic [CFG_W-1:0] r;
        r = '0;
        r[ADU_POS] = e.adu;
        r[PMT_POS] = e.pmt;
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] merge(logic [CFG_W-1:0] old_v,
                                               logic [CFG_W-1:0] new_v,
                                               logic [CFG_W-1:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/envcfg_decode.sv
module envcfg_decode
    import envcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] M_ADDR  = 12'h30A,
    parameter logic [ADDR_W-1:0] MH_ADDR = 12'h31A,
    parameter logic [ADDR_W-1:0] H_ADDR  = 12'h60A,
    parameter logic [ADDR_W-1:0] HH_ADDR = 12'h61A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rv64,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output csr_tgt_e          tgt,
    output logic              miss,
    output wr_req_t           wr
);

    localparam logic [CFG_W-1:0] LO_LANE = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [CFG_W-1:0] HI_LANE = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};

    always_comb begin
        tgt = TGT_NONE;
        if (sel) begin
            if (addr == M_ADDR)                 tgt = TGT_M_LO;
            else if (addr == H_ADDR)            tgt = TGT_H_LO;
            else if (addr == MH_ADDR && !rv64)  tgt = TGT_M_HI;
            else if (addr == HH_ADDR && !rv64)  tgt = TGT_H_HI;
        end
    end

    assign miss = sel && (tgt == TGT_NONE);

    always_comb begin
        wr.m_wr = we && (tgt == TGT_M_LO || tgt == TGT_M_HI);
        wr.h_wr = we && (tgt == TGT_H_LO || tgt == TGT_H_HI);
        if (tgt == TGT_M_HI || tgt == TGT_H_HI) begin
            wr.lane = HI_LANE;
            wr.data = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
        end else if (rv64) begin
            wr.lane = '1;
            wr.data = wdata;
        end else begin
            wr.lane = LO_LANE;
            wr.data = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
        end
    end

    // R8: high-half addresses are absent in 64-bit mode
    a_r8_high_absent: assert property (@(posedge clk) disable iff (rst)
        (sel && rv64 && (addr == MH_ADDR || addr == HH_ADDR)) |-> miss);

    // R7: data never lands outside the selected lane
    a_r7_lane_clean: assert property (@(posedge clk) disable iff (rst)
        (wr.m_wr || wr.h_wr) |-> ((wr.data & ~wr.lane) == '0));

endmodule

// File: rtl/envcfg_mreg.sv
module envcfg_mreg
    import envcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ext_set_t         ext,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] lane,
    input  logic [CFG_W-1:0] data,
    output logic [CFG_W-1:0] q
);

    logic [CFG_W-1:0] wmask;
    assign wmask = lane & (BASE_MASK | ext_bits(ext));

    always_ff @(posedge clk) begin
        if (rst)        q <= reset_word(ext);
        else if (wr_en) q <= merge(q, data, wmask);
    end

    // R2: an absent extension's bit never moves
    a_r2_pmt_hold: assert property (@(posedge clk) disable iff (rst)
        !ext.pmt |=> q[PMT_POS] == $past(q[PMT_POS]));
    a_r2_tmr_hold: assert property (@(posedge clk) disable iff (rst)
        !ext.tmr |=> q[TMR_POS] == $past(q[TMR_POS]));
    a_r2_adu_hold: assert property (@(posedge clk) disable iff (rst)
        !ext.adu |=> q[ADU_POS] == $past(q[ADU_POS]));

    // R3: reserved bits stay zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (q & ~(BASE_MASK | EXT_FIELDS)) == '0);

    // R4: value right after reset
    a_r4_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == reset_word(ext));

endmodule

// File: rtl/envcfg_hreg.sv
module envcfg_hreg
    import envcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ext_set_t         ext,
    input  logic [CFG_W-1:0] m_q,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] lane,
    input  logic [CFG_W-1:0] data,
    output logic [CFG_W-1:0] q,
    output logic [CFG_W-1:0] view
);

    logic [CFG_W-1:0] wmask;
    assign wmask = lane & (BASE_MASK | (m_q & EXT_FIELDS));
    assign view  = q & (~EXT_FIELDS | m_q);

    always_ff @(posedge clk) begin
        if (rst)        q <= reset_word(ext);
        else if (wr_en) q <= merge(q, data, wmask);
    end

    // R5: a cleared machine bit freezes the hypervisor bit on write
    for (genvar g = ADU_POS; g <= TMR_POS; g++) begin : g_gate
        a_r5_gated_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !m_q[g]) |=> q[g] == $past(q[g]));
    end

    // R3: reserved bits stay zero
    a_r3_h_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (q & ~(BASE_MASK | EXT_FIELDS)) == '0);

endmodule

// File: rtl/envcfg_pair.sv
module envcfg_pair
    import envcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] M_ADDR  = 12'h30A,
    parameter logic [ADDR_W-1:0] MH_ADDR = 12'h31A,
    parameter logic [ADDR_W-1:0] H_ADDR  = 12'h60A,
    parameter logic [ADDR_W-1:0] HH_ADDR = 12'h61A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rv64_i,
    input  logic              has_pmt_i,
    input  logic              has_tmr_i,
    input  logic              has_adu_i,
    input  logic              csr_sel_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [63:0]       csr_wdata_i,
    output logic [63:0]       csr_rdata_o,
    output logic              csr_miss_o,
    output logic              host_pmt_en_o,
    output logic              host_adu_en_o,
    output logic              guest_pmt_en_o,
    output logic              guest_adu_en_o,
    output logic              s_tmr_en_o,
    output logic              vs_tmr_en_o
);

    ext_set_t         ext;
    csr_tgt_e         tgt;
    wr_req_t          wr;
    logic [CFG_W-1:0] m_q, h_q, h_view, word;

    assign ext = '{pmt: has_pmt_i, tmr: has_tmr_i, adu: has_adu_i};

    envcfg_decode #(
        .ADDR_W(ADDR_W), .M_ADDR(M_ADDR), .MH_ADDR(MH_ADDR),
        .H_ADDR(H_ADDR), .HH_ADDR(HH_ADDR)
    ) i_dec (
        .clk(clk), .rst(rst), .rv64(rv64_i), .sel(csr_sel_i), .we(csr_we_i),
        .addr(csr_addr_i), .wdata(csr_wdata_i),
        .tgt(tgt), .miss(csr_miss_o), .wr(wr)
    );

    envcfg_mreg i_mreg (
        .clk(clk), .rst(rst), .ext(ext), .wr_en(wr.m_wr),
        .lane(wr.lane), .data(wr.data), .q(m_q)
    );

    envcfg_hreg i_hreg (
        .clk(clk), .rst(rst), .ext(ext), .m_q(m_q), .wr_en(wr.h_wr),
        .lane(wr.lane), .data(wr.data), .q(h_q), .view(h_view)
    );

    always_comb begin
        word = (tgt == TGT_H_LO || tgt == TGT_H_HI) ? h_view : m_q;
        unique case (tgt)
            TGT_NONE:          csr_rdata_o = '0;
            TGT_M_HI, TGT_H_HI: csr_rdata_o = {{HALF_W{1'b0}}, word[CFG_W-1:HALF_W]};
            default:           csr_rdata_o = rv64_i ? word
                                           : {{HALF_W{1'b0}}, word[HALF_W-1:0]};
        endcase
    end

    assign host_pmt_en_o  = m_q[PMT_POS];
    assign host_adu_en_o  = m_q[ADU_POS];
    assign s_tmr_en_o     = m_q[TMR_POS];
    assign guest_pmt_en_o = m_q[PMT_POS] & h_q[PMT_POS];
    assign guest_adu_en_o = m_q[ADU_POS] & h_q[ADU_POS];
    assign vs_tmr_en_o    = m_q[TMR_POS] & h_q[TMR_POS];

    // R10: a guest enable never stands without its host enable
    a_r10_guest_pmt: assert property (@(posedge clk) disable iff (rst)
        guest_pmt_en_o |-> host_pmt_en_o);
    a_r10_guest_adu: assert property (@(posedge clk) disable iff (rst)
        guest_adu_en_o |-> host_adu_en_o);
    a_r10_guest_tmr: assert property (@(posedge clk) disable iff (rst)
        vs_tmr_en_o |-> s_tmr_en_o);

    // R8: a missed access writes nothing
    a_r8_miss_no_write: assert property (@(posedge clk) disable iff (rst)
        csr_miss_o |=> (m_q == $past(m_q)) && (h_q == $past(h_q)));

    // R7: split-mode reads leave the upper half zero
    a_r7_rv32_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !rv64_i |-> csr_rdata_o[CFG_W-1:HALF_W] == '0);

endmodule

// File: tb/test_envcfg_pair.sv
module test_envcfg_pair;

    localparam logic [11:0] A_M  = 12'h30A;
    localparam logic [11:0] A_MH = 12'h31A;
    localparam logic [11:0] A_H  = 12'h60A;
    localparam logic [11:0] A_HH = 12'h61A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rv64 = 1'b1;
    logic        sp = 1'b1, st = 1'b1, sa = 1'b1;
    logic        sel = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        miss, hp, ha, gp, ga, stm, vtm;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    logic [63:0] mm, hh;

    always #10 clk = ~clk;

    envcfg_pair i_envcfg_pair (
        .clk(clk), .rst(rst), .rv64_i(rv64),
        .has_pmt_i(sp), .has_tmr_i(st), .has_adu_i(sa),
        .csr_sel_i(sel), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_rdata_o(rdata), .csr_miss_o(miss),
        .host_pmt_en_o(hp), .host_adu_en_o(ha),
        .guest_pmt_en_o(gp), .guest_adu_en_o(ga),
        .s_tmr_en_o(stm), .vs_tmr_en_o(vtm)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  %0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_can(int i);
        if (i == 0 || (i >= 4 && i <= 7)) return 1;
        if (i == 61) return sa;
        if (i == 62) return sp;
        if (i == 63) return st;
        return 0;
    endfunction

    function automatic bit h_can(int i);
        if (i == 0 || (i >= 4 && i <= 7)) return 1;
        if (i >= 61) return mm[i];
        return 0;
    endfunction

    function automatic logic [63:0] h_seen();
        logic [63:0] v;
        for (int i = 0; i < 64; i++) v[i] = hh[i] && (i < 61 || mm[i]);
        return v;
    endfunction

    // 0 none, 1 machine low, 2 machine high, 3 hyp low, 4 hyp high
    function automatic int region(logic [11:0] a);
        if (a == A_M) return 1;
        if (a == A_H) return 3;
        if (a == A_MH && !rv64) return 2;
        if (a == A_HH && !rv64) return 4;
        return 0;
    endfunction

    task automatic outs_check(string tag);
        chk({tag, " R10 host_pmt"}, 64'(hp), 64'(mm[62]));
        chk({tag, " R10 host_adu"}, 64'(ha), 64'(mm[61]));
        chk({tag, " R10 s_tmr"},    64'(stm), 64'(mm[63]));
        chk({tag, " R10 guest_pmt"}, 64'(gp), 64'(mm[62] && hh[62]));
        chk({tag, " R10 guest_adu"}, 64'(ga), 64'(mm[61] && hh[61]));
        chk({tag, " R10 vs_tmr"},    64'(vtm), 64'(mm[63] && hh[63]));
    endtask

    task automatic acc(string tag, bit w, logic [11:0] a, logic [63:0] d);
        int rg;
        logic [63:0] src, exp;
        @(negedge clk);
        sel = 1'b1; we = w; addr = a; wdata = d;
        #1;
        rg = region(a);
        src = (rg >= 3) ? h_seen() : mm;
        case (rg)
            0: exp = 64'h0;
            2, 4: exp = {32'h0, src[63:32]};
            default: exp = rv64 ? src : {32'h0, src[31:0]};
        endcase
        chk({tag, " R9 rdata"}, rdata, exp);
        chk({tag, " R8 miss"}, 64'(miss), 64'(rg == 0));
        outs_check(tag);
        @(posedge clk);
        if (w && rg != 0) begin
            for (int i = 0; i < 64; i++) begin
                bit in_lane;
                bit b;
                if (rg == 2 || rg == 4) begin
                    in_lane = (i >= 32);
                    b = (i >= 32) ? d[i - 32] : 1'b0;
                end else begin
                    in_lane = rv64 || (i < 32);
                    b = d[i];
                end
                if (in_lane && rg <= 2 && m_can(i)) mm[i] = b;
                if (in_lane && rg >= 3 && h_can(i)) hh[i] = b;
            end
        end
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset(bit mode64, bit p, bit t, bit u);
        @(negedge clk);
        rst = 1'b1; rv64 = mode64; sp = p; st = t; sa = u; sel = 1'b0;
        repeat (2) @(posedge clk);
        mm = 64'h0; mm[62] = p; mm[61] = u;
        hh = mm;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [63:0] lf;
        logic [11:0] alist [6];
        alist[0] = A_M; alist[1] = A_MH; alist[2] = A_H;
        alist[3] = A_HH; alist[4] = 12'h30B; alist[5] = 12'h000;

        // Phase A: 64-bit, all straps present
        do_reset(1, 1, 1, 1);
        acc("R4 m reset", 0, A_M, 0);
        acc("R4 h reset", 0, A_H, 0);
        acc("R1 m write all", 1, A_M, '1);
        acc("R1 R3 m read", 0, A_M, 0);
        acc("R5 h write all", 1, A_H, '1);
        acc("R5 R3 h read", 0, A_H, 0);
        acc("R1 m clear pmt", 1, A_M, 64'hB000_0000_0000_00F1);
        acc("R6 h masked", 0, A_H, 0);
        acc("R5 h write under clear", 1, A_H, 64'h0);
        acc("R1 m restore pmt", 1, A_M, '1);
        acc("R6 h unmasked", 0, A_H, 0);
        acc("R1 m clear tmr", 1, A_M, 64'h7000_0000_0000_0010);
        acc("R5 h set tmr blocked", 1, A_H, '1);
        acc("R6 h read", 0, A_H, 0);
        acc("R8 mh absent", 1, A_MH, 64'h0);
        acc("R8 hh absent", 1, A_HH, 64'h0);
        acc("R8 unknown", 1, 12'h30B, 64'h0);
        acc("R8 after", 0, A_M, 0);

        // Phase B: 32-bit, only memory-type strap
        do_reset(0, 1, 0, 0);
        acc("R4 R7 mh reset", 0, A_MH, 0);
        acc("R2 R7 mh write", 1, A_MH, 64'hFFFF_FFFF_FFFF_FFFF);
        acc("R2 R7 mh read", 0, A_MH, 0);
        acc("R3 R7 m lo write", 1, A_M, 64'hFFFF_FFFF_FFFF_FFFF);
        acc("R7 m lo read", 0, A_M, 0);
        acc("R7 hh write", 1, A_HH, 64'h0000_0000_FFFF_FFFF);
        acc("R7 hh read", 0, A_HH, 0);
        acc("R7 mh clear", 1, A_MH, 64'h0);
        acc("R6 R7 hh masked", 0, A_HH, 0);
        acc("R7 h lo write", 1, A_H, 64'h0000_0000_0000_00A1);
        acc("R7 h lo read", 0, A_H, 0);

        // Phase C: 64-bit, no straps
        do_reset(1, 0, 0, 0);
        acc("R4 m reset none", 0, A_M, 0);
        acc("R2 m write none", 1, A_M, '1);
        acc("R2 m read none", 0, A_M, 0);
        acc("R5 h write none", 1, A_H, '1);
        acc("R5 h read none", 0, A_H, 0);

        // Phase D: pseudo-random sweep in both modes
        lf = 64'h9E37_79B9_7F4A_7C15;
        for (int ph = 0; ph < 4; ph++) begin
            do_reset(ph[0], ph[1] | ph[0], ph[1], !ph[0]);
            for (int k = 0; k < 150; k++) begin
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                acc("R1 R5 R6 sweep", lf[7], alist[int'(lf[15:8]) % 6],
                    {lf[31:0], lf[63:32]});
            end
        end

        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule